// File: doc/BRIEF.md
# UART Interrupt Source Aggregator

This block gathers the interrupt causes of one UART channel into a single level-sensitive request line. Four causes are tracked: received data, a receive error, transmit space and a modem-line change. Each cause latches into a sticky source bit when the neighbouring receive, transmit or modem logic pulses its event input. The bit stays set until software clears it. A mask register blocks individual causes. The pending view is the latched sources with the masked ones removed, and the interrupt output is high while any pending bit is set.

The transmit cause has a second, level-driven origin. While FIFO mode is on, the block compares the transmit FIFO occupancy against a trigger level. That level is a 3-bit trigger field scaled by a factor chosen by the channel index parameter. Whenever the occupancy is at or below the level, the transmit source is set again on every cycle.

Software reaches the pending, source and mask registers through a simple valid/write/address/data port. Reads return data combinationally.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source, mask and pending registers all read 0 and `irq_o` is low.
- R2: A one-cycle pulse on `rx_evt_i`, `err_evt_i`, `tx_taken_i` or `modem_evt_i` sets source bit 0, 1, 2 or 3 respectively, and the bit stays set after the pulse ends.
- R3: The pending register reads source AND NOT mask, and `irq_o` is high exactly when any pending bit is set.
- R4: A mask write takes effect from the next cycle on both pending and `irq_o`. Masking a cause leaves its source bit intact, and the mask reads back as written.
- R5: Writing the source register (address 1) clears every source bit written as 1 and leaves the bits written as 0 unchanged.
- R6: Writing the pending register (address 0) clears the source bits written as 1, so the matching pending bits also drop.
- R7: The transmit trigger level equals `tx_trig_i` times 32 on channel 0, times 8 on channels 1 and 4, and times 2 on channels 2 and 3. Any other channel uses level 0.
- R8: While `fifo_en_i` is 1, the transmit source bit is set on every cycle in which `tx_count_i` is less than or equal to the trigger level. While `fifo_en_i` is 0, the count has no effect.
- R9: If an event sets a source bit in the same cycle that a software write clears it, the bit ends up set.
- R10: Address 0 selects pending, 1 selects source and 2 selects mask. Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register select (0 pending, 1 source, 2 mask, 3 reserved) |
| reg_wdata_i | input | 4 | Write data, one bit per cause |
| reg_rdata_o | output | 4 | Read data for the selected register |
| rx_evt_i | input | 1 | Receive event pulse |
| err_evt_i | input | 1 | Receive error event pulse |
| tx_taken_i | input | 1 | Transmit byte accepted pulse |
| modem_evt_i | input | 1 | Modem status change pulse |
| fifo_en_i | input | 1 | FIFO mode enable |
| tx_trig_i | input | 3 | Transmit trigger field |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with CHANNEL = 1 (scale factor 8) and CNT_W = 8. With these values the trigger fields 0, 2 and 7 give levels 0, 16 and 56, which an 8-bit count can reach exactly and exceed by one, so every level boundary is tested from both sides. The same settings also let the bench check that the level condition keeps setting the transmit bit after software clears it, and that the condition stops counting once FIFO mode is off.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC  = 4;
  localparam int SRC_RX   = 0;
  localparam int SRC_ERR  = 1;
  localparam int SRC_TX   = 2;
  localparam int SRC_MDM  = 3;
  localparam int REG_AW   = 2;
  localparam int TRIG_W   = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_PEND = 2'd0,
    REG_SRC  = 2'd1,
    REG_MASK = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  function automatic int chan_factor(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  output logic              tx_low_o
);
  localparam int FACTOR = chan_factor(CHANNEL);
  localparam int LVL_W  = TRIG_W + 6;
  localparam int CMP_W  = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [LVL_W-1:0] level;

  generate
    if (FACTOR == 0) begin : g_no_level
      assign level = '0;
    end else begin : g_scaled
      assign level = LVL_W'(tx_trig_i) * LVL_W'(FACTOR);
    end
  endgenerate

  assign tx_low_o = fifo_en_i && (CMP_W'(tx_count_i) <= CMP_W'(level));
endmodule

// File: rtl/uart_irq_srcreg.sv
module uart_irq_srcreg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    // set takes priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;
      else if (clr_i[g])  q_o[g] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> q_o[g]); // R9
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[g] && !clr_i[g]) |=> q_o[g]); // R2
    AST_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]); // R5
  end
endmodule

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               write_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] src_clr_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  reg_sel_e sel;
  logic     we;

  assign sel = reg_sel_e'(addr_i);
  assign we  = valid_i && write_i;

  // both pending and source writes clear source bits
  assign src_clr_o = (we && (sel == REG_PEND || sel == REG_SRC)) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mask_o <= '0;
    else if (we && sel == REG_MASK)   mask_o <= wdata_i;
  end

  always_comb begin
    case (sel)
      REG_PEND: rdata_o = pend_i;
      REG_SRC:  rdata_o = src_i;
      REG_MASK: rdata_o = mask_o;
      default:  rdata_o = '0;
    endcase
  end

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && sel == REG_MASK) |=> (mask_o == $past(wdata_i))); // R4
  AST_RSVD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && sel == REG_RSVD) |=> $stable(mask_o)); // R10
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_valid_i,
  input  logic               reg_write_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  input  logic               rx_evt_i,
  input  logic               err_evt_i,
  input  logic               tx_taken_i,
  input  logic               modem_evt_i,
  input  logic               fifo_en_i,
  input  logic [TRIG_W-1:0]  tx_trig_i,
  input  logic [CNT_W-1:0]   tx_count_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_set, src_clr, src_q, mask_q, pend;
  logic               tx_low;

  uart_irq_trig #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_trig (
    .fifo_en_i  (fifo_en_i),
    .tx_trig_i  (tx_trig_i),
    .tx_count_i (tx_count_i),
    .tx_low_o   (tx_low)
  );

  always_comb begin
    src_set          = '0;
    src_set[SRC_RX]  = rx_evt_i;
    src_set[SRC_ERR] = err_evt_i;
    src_set[SRC_TX]  = tx_taken_i || tx_low;
    src_set[SRC_MDM] = modem_evt_i;
  end

  uart_irq_srcreg #(.N(NUM_SRC)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set),
    .clr_i  (src_clr),
    .q_o    (src_q)
  );

  uart_irq_regif u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (reg_valid_i),
    .write_i   (reg_write_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .src_i     (src_q),
    .pend_i    (pend),
    .src_clr_o (src_clr),
    .mask_o    (mask_q),
    .rdata_o   (reg_rdata_o)
  );

  assign pend  = src_q & ~mask_q;
  assign irq_o = |pend;

  AST_TX_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_low |=> src_q[SRC_TX]); // R8
  AST_FIFO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !tx_taken_i && !src_q[SRC_TX]) |=> !src_q[SRC_TX]); // R8
  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && reg_addr_i == REG_MASK && (&reg_wdata_i)) |=> !irq_o); // R4
  AST_RX_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i |=> src_q[SRC_RX]); // R2
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, write = 1'b0;
  logic [1:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       rx_evt = 1'b0, err_evt = 1'b0, tx_taken = 1'b0, modem_evt = 1'b0;
  logic       fifo_en = 1'b0;
  logic [2:0] tx_trig = '0;
  logic [7:0] tx_count = '0;
  logic       irq;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(1), .CNT_W(8)) u_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_evt_i(rx_evt), .err_evt_i(err_evt), .tx_taken_i(tx_taken), .modem_evt_i(modem_evt),
    .fifo_en_i(fifo_en), .tx_trig_i(tx_trig), .tx_count_i(tx_count),
    .irq_o(irq)
  );

  typedef struct {
    logic [3:0] rd;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  event smp_ev;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  // monitor: pops expected items and compares against the outputs
  initial forever begin
    @(smp_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (rdata !== e.rd || irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, rdata, irq, e.rd, e.irq);
      end
    end
  end

  task automatic rd_chk(input logic [1:0] a, input logic [3:0] er, input logic ei, input string tag);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    #1;
    exp_q.push_back(exp_t'{rd: er, irq: ei, tag: tag});
    -> smp_ev;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  // ev = {modem, tx_taken, err, rx}
  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    {modem_evt, tx_taken, err_evt, rx_evt} = ev;
    @(negedge clk);
    {modem_evt, tx_taken, err_evt, rx_evt} = '0;
  endtask

  task automatic set_tx(input logic en, input logic [2:0] trig, input logic [7:0] cnt);
    @(negedge clk);
    fifo_en = en; tx_trig = trig; tx_count = cnt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_chk(2'd1, 4'h0, 1'b0, "R1 source after reset");
    rd_chk(2'd0, 4'h0, 1'b0, "R1 pending after reset");
    rd_chk(2'd2, 4'h0, 1'b0, "R1 mask after reset");

    pulse(4'b0001);
    rd_chk(2'd1, 4'b0001, 1'b1, "R2 rx sets bit0");
    rd_chk(2'd0, 4'b0001, 1'b1, "R3 pending follows source");

    wr(2'd2, 4'b0001);
    rd_chk(2'd0, 4'b0000, 1'b0, "R4 masked pending");
    rd_chk(2'd1, 4'b0001, 1'b0, "R4 source kept under mask");
    rd_chk(2'd2, 4'b0001, 1'b0, "R4 mask readback");

    pulse(4'b1010);
    rd_chk(2'd1, 4'b1011, 1'b1, "R2 err and modem bits");
    rd_chk(2'd0, 4'b1010, 1'b1, "R3 pending with mask");

    wr(2'd1, 4'b0010);
    rd_chk(2'd1, 4'b1001, 1'b1, "R5 source clear bit1 only");

    wr(2'd0, 4'b1000);
    rd_chk(2'd1, 4'b0001, 1'b0, "R6 pending write clears source");
    rd_chk(2'd0, 4'b0000, 1'b0, "R6 pending dropped");

    wr(2'd2, 4'b0000);
    rd_chk(2'd0, 4'b0001, 1'b1, "R4 unmask raises irq");
    wr(2'd1, 4'hF);
    rd_chk(2'd1, 4'h0, 1'b0, "R5 clear all");

    pulse(4'b0100);
    rd_chk(2'd1, 4'b0100, 1'b1, "R2 tx taken sets bit2");
    wr(2'd1, 4'hF);

    // same-cycle event and clear of bit0
    @(negedge clk);
    rx_evt = 1'b1; valid = 1'b1; write = 1'b1; addr = 2'd1; wdata = 4'b0001;
    @(negedge clk);
    rx_evt = 1'b0; valid = 1'b0; write = 1'b0;
    rd_chk(2'd1, 4'b0001, 1'b1, "R9 set beats clear");
    wr(2'd1, 4'hF);

    wr(2'd2, 4'b0011);
    wr(2'd3, 4'hF);
    rd_chk(2'd2, 4'b0011, 1'b0, "R10 reserved write leaves mask");
    rd_chk(2'd3, 4'h0, 1'b0, "R10 reserved reads zero");
    pulse(4'b0001);
    wr(2'd3, 4'hF);
    rd_chk(2'd1, 4'b0001, 1'b0, "R10 reserved write leaves source");
    wr(2'd2, 4'h0);
    wr(2'd1, 4'hF);

    set_tx(1'b1, 3'd2, 8'd17);
    wr(2'd1, 4'hF);
    rd_chk(2'd1, 4'h0, 1'b0, "R8 count above level 16");
    set_tx(1'b1, 3'd2, 8'd16);
    rd_chk(2'd1, 4'b0100, 1'b1, "R8 count equal level 16");
    wr(2'd1, 4'hF);
    rd_chk(2'd1, 4'b0100, 1'b1, "R8 reasserts after clear");
    set_tx(1'b1, 3'd2, 8'd17);
    wr(2'd1, 4'hF);
    rd_chk(2'd1, 4'h0, 1'b0, "R8 clear holds above level");
    set_tx(1'b1, 3'd2, 8'd3);
    rd_chk(2'd1, 4'b0100, 1'b1, "R8 count below level");

    set_tx(1'b1, 3'd0, 8'd1);
    wr(2'd1, 4'hF);
    rd_chk(2'd1, 4'h0, 1'b0, "R7 field 0 count 1");
    set_tx(1'b1, 3'd0, 8'd0);
    rd_chk(2'd1, 4'b0100, 1'b1, "R7 field 0 count 0");

    set_tx(1'b1, 3'd7, 8'd57);
    wr(2'd1, 4'hF);
    rd_chk(2'd1, 4'h0, 1'b0, "R7 level 56 count 57");
    set_tx(1'b1, 3'd7, 8'd56);
    rd_chk(2'd1, 4'b0100, 1'b1, "R7 level 56 count 56");

    set_tx(1'b0, 3'd0, 8'd0);
    wr(2'd1, 4'hF);
    rd_chk(2'd1, 4'h0, 1'b0, "R8 fifo off ignores count");

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule